// File: doc/BRIEF.md
# Configurable Quasi-Bidirectional GPIO Ports

This block drives thirteen general-purpose pins, grouped into four ports of up to four pins each. The last port holds only the pin left over after the first three. Every pin has its own output data bit and a two-bit driver mode. The mode is kept as one bit in each of two mode registers. For each pin the block produces two pad controls: a pull-down enable and a strong pull-up enable. An external pad with a weak pull-up resistor turns these into a level. The pad level comes back on the input side, passes through a two-flop synchroniser and can then be read.

Software-side access has two paths. The first is a port-wide register port, which writes a whole port of data or mode bits at once and reads data, mode or pin level one port at a time. The second is a single-pin path, which sets one output data bit and returns one synchronised pin level. Quasi-bidirectional mode is the reset mode of every pin. In that mode a pin acts as open-drain, except that a rising output bit drives the pad strongly high for one clock to sharpen the edge.

Top module: `gpio_ports`

## Requirements
- R1: After synchronous reset, every output data bit is 1 and every mode bit is 0 (quasi-bidirectional), so no pin enables its pull-down or its strong pull-up.
- R2: A port access uses the address {sel[1:0], port[1:0]}. sel 0 is output data, 1 is the low mode bit, 2 is the high mode bit and 3 is the synchronised pin level (read-only; a write there changes nothing). Port p covers pins 4p to 4p+3. In port 3 only bit 0 exists: writes to bits 3:1 are ignored and reads of them return 0.
- R3: A single-pin write sets data bit bit_sel to bit_val. An index of 13 or more changes nothing. If a port-wide data write lands in the same cycle, the single-pin value wins for its own pin and the port write still applies to every other pin.
- R4: With mode {high,low} = 11 (open-drain), the pull-down is on exactly when the data bit is 0, and the strong pull-up is never on.
- R5: With mode 01 (push-pull), the pull-down follows the inverted data bit and the strong pull-up follows the data bit.
- R6: With mode 10 (high-impedance), both the pull-down and the strong pull-up are off, whatever the data bit holds.
- R7: With mode 00 (quasi-bidirectional), the pull-down follows the inverted data bit. The strong pull-up is on for exactly the one clock that follows a 0-to-1 change of the data bit, and off otherwise.
- R8: The quasi pull-up pulse does not retrigger when a 1 is written over a 1. It ends at once when the mode leaves quasi-bidirectional. Entering quasi mode with the data already at 1 gives no pulse.
- R9: A pad level reaches the pin-level read paths (sel 3 and bit_rd) on the second rising clock edge after it changes. bit_rd returns 0 for indexes of 13 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Port-wide write strobe |
| wr_addr | input | 4 | Write address {sel, port} |
| wr_data | input | 4 | Write data, one bit per pin of the port |
| rd_addr | input | 4 | Read address {sel, port} |
| rd_data | output | 4 | Combinational read data |
| bit_we | input | 1 | Single-pin data write strobe |
| bit_sel | input | 4 | Pin index for single-pin write and read |
| bit_val | input | 1 | Data value for a single-pin write |
| bit_rd | output | 1 | Synchronised level of pin bit_sel |
| pad_in | input | 13 | Pad levels seen at the pins |
| pad_pd_en | output | 13 | Per-pin pull-down enable |
| pad_pu_en | output | 13 | Per-pin strong pull-up enable |

## Verification
Two events can land on the same clock edge. The first is a port-wide data write together with a single-pin write. The bench drives both strobes in one cycle, once aimed at the same port and once at different ports, and compares the data read back with the single-pin-wins rule. The second is a rising data bit together with a mode change away from quasi-bidirectional. The bench raises a pin through the single-pin path while, in the same cycle, writing the high mode bit. It then expects no strong pull-up in the cycle where the pulse would otherwise appear, and no late pulse when the pin returns to quasi mode.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Driver mode of one pin, stored as {high mode bit, low mode bit}.
    typedef enum logic [1:0] {
        MODE_QUASI = 2'b00,
        MODE_PUSH  = 2'b01,
        MODE_FLOAT = 2'b10,
        MODE_DRAIN = 2'b11
    } pin_mode_e;

    // Register class selected by the upper two address bits.
    typedef enum logic [1:0] {
        SEL_DOUT    = 2'b00,
        SEL_MODE_LO = 2'b01,
        SEL_MODE_HI = 2'b10,
        SEL_LEVEL   = 2'b11
    } reg_sel_e;

    // Pad controls produced for one pin.
    typedef struct packed {
        logic pull_dn;
        logic pull_up;
    } drive_t;

    // Pad controls for a pin, given its mode, its data bit and whether
    // the data bit rose on the last edge.
    function automatic drive_t drive_for(pin_mode_e mode, logic dout, logic rise);
        drive_t r;
        r.pull_dn = 1'b0;
        r.pull_up = 1'b0;
        case (mode)
            MODE_QUASI: begin
                r.pull_dn = ~dout;
                r.pull_up = rise;
            end
            MODE_PUSH: begin
                r.pull_dn = ~dout;
                r.pull_up = dout;
            end
            MODE_DRAIN: r.pull_dn = ~dout;
            default: begin
                r.pull_dn = 1'b0;
                r.pull_up = 1'b0;
            end
        endcase
        return r;
    endfunction

    // Number of ports needed to hold a given pin count.
    function automatic int unsigned port_count(int unsigned pins, int unsigned width);
        return (pins + width - 1) / width;
    endfunction

    // Index width for a given number of selectable items (at least 1).
    function automatic int unsigned sel_width(int unsigned items);
        return (items > 1) ? $clog2(items) : 1;
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PINS = 13,
    parameter int unsigned PORT_W   = 4,
    parameter int unsigned PSEL_W   = 2,
    parameter int unsigned IDX_W    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  reg_sel_e            wr_sel,
    input  logic [PSEL_W-1:0]   wr_port,
    input  logic [PORT_W-1:0]   wr_data,
    input  logic                bit_we,
    input  logic [IDX_W-1:0]    bit_idx,
    input  logic                bit_val,
    output logic [NUM_PINS-1:0] dout_q,
    output logic [NUM_PINS-1:0] mode_lo_q,
    output logic [NUM_PINS-1:0] mode_hi_q
);

    // One storage cell per existing pin; positions past the last pin
    // have no cell, so writes aimed there fall away.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam int unsigned        LANE  = i % PORT_W;
        localparam logic [PSEL_W-1:0]  OWNER = PSEL_W'(i / PORT_W);
        localparam logic [IDX_W-1:0]   SELF  = IDX_W'(i);

        logic port_hit;
        logic pin_hit;
        logic d_r;
        logic lo_r;
        logic hi_r;

        assign port_hit = wr_en  && (wr_port == OWNER);
        assign pin_hit  = bit_we && (bit_idx == SELF);

        always_ff @(posedge clk) begin
            if (rst) begin
                d_r  <= 1'b1;
                lo_r <= 1'b0;
                hi_r <= 1'b0;
            end else begin
                if (pin_hit) begin
                    d_r <= bit_val;
                end else if (port_hit && (wr_sel == SEL_DOUT)) begin
                    d_r <= wr_data[LANE];
                end
                if (port_hit && (wr_sel == SEL_MODE_LO)) begin
                    lo_r <= wr_data[LANE];
                end
                if (port_hit && (wr_sel == SEL_MODE_HI)) begin
                    hi_r <= wr_data[LANE];
                end
            end
        end

        assign dout_q[i]    = d_r;
        assign mode_lo_q[i] = lo_r;
        assign mode_hi_q[i] = hi_r;
    end

endmodule

// File: rtl/gpio_drv.sv
module gpio_drv
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PINS = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] dout,
    input  logic [NUM_PINS-1:0] mode_lo,
    input  logic [NUM_PINS-1:0] mode_hi,
    output logic [NUM_PINS-1:0] pull_dn,
    output logic [NUM_PINS-1:0] pull_up
);

    // Data bits as they stood one edge ago; reset high like the data
    // itself, so leaving reset produces no edge.
    logic [NUM_PINS-1:0] dout_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_prev <= '1;
        end else begin
            dout_prev <= dout;
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_mode_e mode;
        drive_t    drv;

        assign mode       = pin_mode_e'({mode_hi[i], mode_lo[i]});
        assign drv        = drive_for(mode, dout[i], dout[i] & ~dout_prev[i]);
        assign pull_dn[i] = drv.pull_dn;
        assign pull_up[i] = drv.pull_up;
    end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= async_in;
            stage2 <= stage1;
        end
    end

    assign sync_out = stage2;

endmodule

// File: rtl/gpio_ports.sv
module gpio_ports
    import gpio_pkg::*;
#(
    parameter  int unsigned NUM_PINS  = 13,
    parameter  int unsigned PORT_W    = 4,
    localparam int unsigned NUM_PORTS = port_count(NUM_PINS, PORT_W),
    localparam int unsigned PSEL_W    = sel_width(NUM_PORTS),
    localparam int unsigned IDX_W     = sel_width(NUM_PINS),
    localparam int unsigned ADDR_W    = PSEL_W + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [PORT_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [PORT_W-1:0]   rd_data,
    input  logic                bit_we,
    input  logic [IDX_W-1:0]    bit_sel,
    input  logic                bit_val,
    output logic                bit_rd,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_pd_en,
    output logic [NUM_PINS-1:0] pad_pu_en
);

    localparam int unsigned BANKS    = 2 ** PSEL_W;
    localparam int unsigned IDX_SPAN = 2 ** IDX_W;

    logic [NUM_PINS-1:0] dout_q;
    logic [NUM_PINS-1:0] mode_lo_q;
    logic [NUM_PINS-1:0] mode_hi_q;
    logic [NUM_PINS-1:0] level_q;

    reg_sel_e wr_sel;
    reg_sel_e rd_sel;

    assign wr_sel = reg_sel_e'(wr_addr[ADDR_W-1 -: 2]);
    assign rd_sel = reg_sel_e'(rd_addr[ADDR_W-1 -: 2]);

    gpio_regs #(
        .NUM_PINS (NUM_PINS),
        .PORT_W   (PORT_W),
        .PSEL_W   (PSEL_W),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_port   (wr_addr[PSEL_W-1:0]),
        .wr_data   (wr_data),
        .bit_we    (bit_we),
        .bit_idx   (bit_sel),
        .bit_val   (bit_val),
        .dout_q    (dout_q),
        .mode_lo_q (mode_lo_q),
        .mode_hi_q (mode_hi_q)
    );

    gpio_drv #(
        .NUM_PINS (NUM_PINS)
    ) u_drv (
        .clk     (clk),
        .rst     (rst),
        .dout    (dout_q),
        .mode_lo (mode_lo_q),
        .mode_hi (mode_hi_q),
        .pull_dn (pad_pd_en),
        .pull_up (pad_pu_en)
    );

    gpio_sync #(
        .WIDTH (NUM_PINS)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (level_q)
    );

    // Port-wide read: pick the register class, then slice out one port,
    // zero-filling positions past the last pin.
    logic [NUM_PINS-1:0] rd_src;

    always_comb begin
        case (rd_sel)
            SEL_DOUT:    rd_src = dout_q;
            SEL_MODE_LO: rd_src = mode_lo_q;
            SEL_MODE_HI: rd_src = mode_hi_q;
            default:     rd_src = level_q;
        endcase
    end

    logic [PORT_W-1:0] lane_bank [BANKS];

    for (genvar p = 0; p < BANKS; p++) begin : g_bank
        for (genvar k = 0; k < PORT_W; k++) begin : g_lane
            if (p * PORT_W + k < NUM_PINS) begin : g_real
                assign lane_bank[p][k] = rd_src[p * PORT_W + k];
            end else begin : g_pad
                assign lane_bank[p][k] = 1'b0;
            end
        end
    end

    assign rd_data = lane_bank[rd_addr[PSEL_W-1:0]];

    // Single-pin read of the synchronised level.
    logic [IDX_SPAN-1:0] level_wide;

    assign level_wide = IDX_SPAN'(level_q);
    assign bit_rd     = level_wide[bit_sel];

endmodule

// File: rtl/gpio_ports_chk.sv
module gpio_ports_chk
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PINS = 13
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] dout_q,
    input logic [NUM_PINS-1:0] mode_lo_q,
    input logic [NUM_PINS-1:0] mode_hi_q,
    input logic [NUM_PINS-1:0] level_q,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] pad_pd_en,
    input logic [NUM_PINS-1:0] pad_pu_en
);

    // Cycles since reset, saturating at 2, so the synchroniser check
    // never looks back past reset.
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= 2'd0;
        end else if (age != 2'd2) begin
            age <= age + 2'd1;
        end
    end

    // R9: the level read path is exactly two edges behind the pad.
    a_r9_sync_depth: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (level_q == $past(pad_in, 2)));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_mode_e mode;
        assign mode = pin_mode_e'({mode_hi_q[i], mode_lo_q[i]});

        // R6: a floating pin drives nothing.
        a_r6_float_quiet: assert property (@(posedge clk) disable iff (rst)
            (mode == MODE_FLOAT) |-> (!pad_pd_en[i] && !pad_pu_en[i]));

        // R4: open-drain never pulls up and pulls down on a 0.
        a_r4_drain_low_only: assert property (@(posedge clk) disable iff (rst)
            (mode == MODE_DRAIN) |-> (!pad_pu_en[i] && (pad_pd_en[i] == !dout_q[i])));

        // R5: push-pull drives both ways.
        a_r5_push_both: assert property (@(posedge clk) disable iff (rst)
            (mode == MODE_PUSH) |-> ((pad_pu_en[i] == dout_q[i]) && (pad_pd_en[i] != dout_q[i])));

        // R7: a quasi pull-up pulse lasts a single cycle.
        a_r7_pulse_single: assert property (@(posedge clk) disable iff (rst)
            ((mode == MODE_QUASI) && pad_pu_en[i]) |=> !pad_pu_en[i]);

        // R8: a quasi pull-up only appears right after a rising data bit.
        a_r8_pulse_on_rise: assert property (@(posedge clk) disable iff (rst)
            ((mode == MODE_QUASI) && pad_pu_en[i]) |-> $rose(dout_q[i]));

        // R7: pull-up and pull-down are never both on.
        a_r7_no_fight: assert property (@(posedge clk) disable iff (rst)
            pad_pu_en[i] |-> !pad_pd_en[i]);
    end

endmodule

bind gpio_ports gpio_ports_chk #(
    .NUM_PINS (NUM_PINS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dout_q    (dout_q),
    .mode_lo_q (mode_lo_q),
    .mode_hi_q (mode_hi_q),
    .level_q   (level_q),
    .pad_in    (pad_in),
    .pad_pd_en (pad_pd_en),
    .pad_pu_en (pad_pu_en)
);

// File: tb/sim_gpio_ports.sv
module sim_gpio_ports;

    localparam logic [1:0] S_DOUT = 2'd0;
    localparam logic [1:0] S_LO   = 2'd1;
    localparam logic [1:0] S_HI   = 2'd2;
    localparam logic [1:0] S_LVL  = 2'd3;
    localparam logic [15:0] IMPL  = 16'h1FFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [3:0]  wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [3:0]  rd_data;
    logic        bit_we = 1'b0;
    logic [3:0]  bit_sel = '0;
    logic        bit_val = 1'b0;
    logic        bit_rd;
    logic [12:0] pad_in;
    logic [12:0] pad_pd_en;
    logic [12:0] pad_pu_en;
    logic [12:0] ext_low = '0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Expected state, kept from the requirements.
    logic [15:0] m_dout = 16'hFFFF;
    logic [15:0] m_lo   = '0;
    logic [15:0] m_hi   = '0;
    logic [15:0] m_rise = '0;

    always #5ns clk = ~clk;

    // Pad: weak pull-up, pulled low by the block or by an external driver.
    assign pad_in = ~(pad_pd_en | ext_low);

    gpio_ports u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .bit_we    (bit_we),
        .bit_sel   (bit_sel),
        .bit_val   (bit_val),
        .bit_rd    (bit_rd),
        .pad_in    (pad_in),
        .pad_pd_en (pad_pd_en),
        .pad_pu_en (pad_pu_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_pd();
        return ~m_dout & ~(m_hi & ~m_lo);
    endfunction

    function automatic logic [15:0] exp_pu();
        return (~m_hi & ~m_lo & m_rise) | (~m_hi & m_lo & m_dout);
    endfunction

    function automatic logic [15:0] exp_level();
        logic [15:0] pd;
        pd = exp_pd();
        return ~(pd | {3'b000, ext_low});
    endfunction

    function automatic logic [3:0] port_val(input logic [15:0] v, input int p);
        return 4'((v & IMPL) >> (4 * p));
    endfunction

    function automatic logic [15:0] put_port(input logic [15:0] v, input int p, input logic [3:0] d);
        return (v & ~(16'hF << (4 * p))) | (16'(d) << (4 * p));
    endfunction

    function automatic logic [15:0] put_bit(input logic [15:0] v, input int idx, input logic b);
        if (idx >= 13) return v;
        return (v & ~(16'h1 << idx)) | (16'(b) << idx);
    endfunction

    // All tasks start and end at a falling edge.
    task automatic step();
        @(negedge clk);
        m_rise = '0;
    endtask

    task automatic model_port(input logic [1:0] sel, input int p, input logic [3:0] v);
        case (sel)
            S_DOUT: m_dout = put_port(m_dout, p, v);
            S_LO:   m_lo   = put_port(m_lo, p, v);
            S_HI:   m_hi   = put_port(m_hi, p, v);
            default: ;
        endcase
    endtask

    task automatic port_write(input logic [1:0] sel, input int p, input logic [3:0] v);
        logic [15:0] old;
        old = m_dout;
        model_port(sel, p, v);
        wr_en = 1'b1; wr_addr = {sel, 2'(p)}; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        m_rise = m_dout & ~old;
    endtask

    task automatic both_write(input logic [1:0] sel, input int p, input logic [3:0] v,
                              input int idx, input logic b);
        logic [15:0] old;
        old = m_dout;
        model_port(sel, p, v);
        m_dout = put_bit(m_dout, idx, b);
        wr_en = 1'b1; wr_addr = {sel, 2'(p)}; wr_data = v;
        bit_we = 1'b1; bit_sel = 4'(idx); bit_val = b;
        @(negedge clk);
        wr_en = 1'b0; bit_we = 1'b0;
        m_rise = m_dout & ~old;
    endtask

    task automatic bit_write(input int idx, input logic b);
        logic [15:0] old;
        old = m_dout;
        m_dout = put_bit(m_dout, idx, b);
        bit_we = 1'b1; bit_sel = 4'(idx); bit_val = b;
        @(negedge clk);
        bit_we = 1'b0;
        m_rise = m_dout & ~old;
    endtask

    task automatic read_port(input logic [1:0] sel, input int p, output logic [3:0] v);
        rd_addr = {sel, 2'(p)};
        #1ns;
        v = rd_data;
    endtask

    task automatic chk_drive(input string tag);
        logic [15:0] pd;
        logic [15:0] pu;
        pd = exp_pd();
        pu = exp_pu();
        chk({tag, " pull-down"}, 32'(pad_pd_en), 32'(pd[12:0]));
        chk({tag, " pull-up"}, 32'(pad_pu_en), 32'(pu[12:0]));
    endtask

    task automatic set_mode(input logic [1:0] m);
        for (int p = 0; p < 4; p++) port_write(S_LO, p, {4{m[0]}});
        for (int p = 0; p < 4; p++) port_write(S_HI, p, {4{m[1]}});
        step();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] rv;
        logic [15:0] lv;
        string tg;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();

        // R1: reset state.
        chk_drive("R1 reset");
        for (int p = 0; p < 4; p++) begin
            read_port(S_DOUT, p, rv);
            chk("R1 data reset", 32'(rv), 32'(port_val(16'hFFFF, p)));
            read_port(S_LO, p, rv);
            chk("R1 mode-low reset", 32'(rv), 32'h0);
            read_port(S_HI, p, rv);
            chk("R1 mode-high reset", 32'(rv), 32'h0);
        end

        // Exhaustive per-port data sweep in every mode.
        for (int m = 0; m < 4; m++) begin
            set_mode(2'(m));
            read_port(S_LO, 3, rv);
            chk("R2 port3 mode-low readback", 32'(rv), 32'(m[0] ? 4'h1 : 4'h0));
            read_port(S_HI, 0, rv);
            chk("R2 port0 mode-high readback", 32'(rv), 32'(m[1] ? 4'hF : 4'h0));
            case (m)
                0: tg = "R7 quasi";
                1: tg = "R5 push";
                2: tg = "R6 float";
                default: tg = "R4 drain";
            endcase
            for (int p = 0; p < 4; p++) begin
                for (int v = 0; v < 16; v++) begin
                    port_write(S_DOUT, p, 4'(v));
                    chk_drive({tg, " write cycle"});
                    read_port(S_DOUT, p, rv);
                    chk("R2 data readback", 32'(rv), 32'(port_val(m_dout, p)));
                    step();
                    chk_drive({tg, " next cycle"});
                    step();
                    lv = exp_level();
                    read_port(S_LVL, p, rv);
                    chk("R9 port level", 32'(rv), 32'(port_val(lv, p)));
                end
            end
            // R2: a write to the level class changes nothing.
            port_write(S_LVL, 0, ~port_val(m_dout, 0));
            chk_drive("R2 level-class write ignored");
            read_port(S_DOUT, 0, rv);
            chk("R2 level-class write ignored", 32'(rv), 32'(port_val(m_dout, 0)));
        end

        // R3: single-pin writes in push-pull mode.
        set_mode(2'b01);
        for (int p = 0; p < 4; p++) port_write(S_DOUT, p, 4'hF);
        for (int idx = 0; idx < 16; idx++) begin
            bit_write(idx, 1'b0);
            chk_drive("R3 single-pin clear");
            for (int p = 0; p < 4; p++) begin
                read_port(S_DOUT, p, rv);
                chk("R3 single-pin readback", 32'(rv), 32'(port_val(m_dout, p)));
            end
            step();
            bit_write(idx, 1'b1);
            chk_drive("R3 single-pin set");
            step();
        end
        // R3: same-port collision, single pin wins.
        both_write(S_DOUT, 0, 4'h0, 2, 1'b1);
        read_port(S_DOUT, 0, rv);
        chk("R3 same-port collision", 32'(rv), 32'h4);
        chk_drive("R3 same-port collision");
        step();
        // R3: different-port collision, both apply.
        both_write(S_DOUT, 1, 4'hA, 0, 1'b0);
        read_port(S_DOUT, 1, rv);
        chk("R3 cross-port collision port1", 32'(rv), 32'hA);
        read_port(S_DOUT, 0, rv);
        chk("R3 cross-port collision port0", 32'(rv), 32'h4);
        step();

        // R9: synchroniser depth and single-pin level read, pins floating.
        set_mode(2'b10);
        step();
        for (int k = 0; k < 13; k++) begin
            ext_low = 13'h1 << k;
            bit_sel = 4'(k);
            step();
            #1ns;
            chk("R9 level still old after one edge", 32'(bit_rd), 32'h1);
            step();
            #1ns;
            chk("R9 level after two edges", 32'(bit_rd), 32'h0);
            read_port(S_LVL, k / 4, rv);
            chk("R9 port level external low", 32'(rv), 32'(port_val(exp_level(), k / 4)));
            ext_low = '0;
            step();
            step();
        end
        for (int k = 13; k < 16; k++) begin
            bit_sel = 4'(k);
            #1ns;
            chk("R9 unimplemented pin reads 0", 32'(bit_rd), 32'h0);
        end
        step();

        // R8: quasi mode retrigger and mode-change cases on pin 6.
        set_mode(2'b00);
        bit_write(6, 1'b0);
        step();
        bit_write(6, 1'b1);
        chk("R7 pulse on rise", 32'(pad_pu_en[6]), 32'h1);
        step();
        chk("R7 pulse over", 32'(pad_pu_en[6]), 32'h0);
        bit_write(6, 1'b1);
        chk("R8 no retrigger on 1 over 1", 32'(pad_pu_en[6]), 32'h0);
        chk_drive("R8 no retrigger");
        step();
        bit_write(6, 1'b0);
        step();
        // Rise and leaving quasi mode on the same edge.
        both_write(S_HI, 1, 4'hF, 6, 1'b1);
        chk("R8 pulse cut by mode change", 32'(pad_pu_en[6]), 32'h0);
        chk_drive("R8 pulse cut by mode change");
        step();
        port_write(S_HI, 1, 4'h0);
        chk("R8 no pulse on return to quasi", 32'(pad_pu_en[6]), 32'h0);
        chk_drive("R8 return to quasi");
        step();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule